// File: doc/BRIEF.md
# DMA Page Map Address Translator

This block sits inside a peripheral DMA adapter and turns the adapter's virtual transfer address into a physical memory address. It keeps a table of map words, one per 512-byte page of the virtual window. The upper bits of the virtual address choose a map word. The low bits are the offset inside the page and pass through unchanged. Each map word carries a valid flag and a physical page frame number.

Software fills the table through a host port that moves one 32-bit word per map slot. The transfer engine presents a virtual address on the translate port. One clock later it receives the physical address and a hit or miss result. A miss also produces a one-cycle invalid-map error pulse. Every lookup copies the map word it used into a selected-map register, which the host can read as a port. This happens whether or not the lookup hits.

An adapter-level init clears only the selected-map register. The table itself is wiped only by the power-up reset.

Top module: `dmamap_xlate`

## Requirements
- R1: While `rst_n` is low (power-up clear), every map slot is zeroed and `smr`, `host_rdata`, `xl_pa`, `xl_done`, `xl_ok` and `inv_map_err` are 0.
- R2: A host write stores only bit 31 (valid flag) and bits 20:0 (page frame number) of `host_wdata` into slot `host_idx`. A host read returns that word, with all other bits 0, on `host_rdata` one clock after `host_rd` is sampled.
- R3: A lookup uses `xl_va[16:9]` as the slot index. One clock after `xl_req` is sampled, it presents `xl_pa` = page frame number × 512 + `xl_va[8:0]`, with `xl_done` high.
- R4: A lookup through a slot whose bit 31 is 1 gives `xl_ok` = 1 and `inv_map_err` = 0.
- R5: A lookup through a slot whose bit 31 is 0 gives `xl_ok` = 0, `xl_pa` = 0 and `inv_map_err` = 1.
- R6: Every completed lookup, hit or miss, loads the full stored map word into `smr`.
- R7: `init` clears `smr` on the next clock and leaves the table intact. A lookup requested in the same cycle as `init` is dropped: no `xl_done` and no error.
- R8: When a host write and a lookup target the same slot in the same cycle, the lookup uses the old word and the write still takes effect.
- R9: `xl_done` and `inv_map_err` are single-cycle pulses. They are low in any cycle that follows a cycle without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up clear, asynchronous |
| init | input | 1 | Adapter init: clears the selected-map register |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_idx | input | 8 | Map slot addressed by the host |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word, registered |
| xl_req | input | 1 | Translate request |
| xl_va | input | 17 | Virtual address to translate |
| xl_done | output | 1 | Result valid pulse |
| xl_ok | output | 1 | Translation hit |
| xl_pa | output | 30 | Physical address |
| inv_map_err | output | 1 | Invalid-map error pulse |
| smr | output | 32 | Selected-map register |

## Verification
A corrupted map slot shows up one clock after a lookup touches it, in three places. `xl_pa` takes a wrong frame number, `xl_ok` can flip, and `smr` holds the bad word. A host read of that slot shows the same error one clock after the read strobe.

A wrong pass-through of the page offset is visible in the low nine bits of `xl_pa` on the first lookup. A stuck lookup status shows up in the very next idle cycle, as a lingering `xl_done` or `inv_map_err`. A write-versus-lookup ordering fault appears only in the same-cycle collision test, so that case is driven explicitly.

// File: rtl/dmamap_pkg.sv
package dmamap_pkg;
   typedef enum logic [1:0] {
      XL_IDLE = 2'd0,
      XL_HIT  = 2'd1,
      XL_MISS = 2'd2
   } xl_stat_e;

   localparam int unsigned DEF_VA_W      = 17;
   localparam int unsigned DEF_OFS_W     = 9;
   localparam int unsigned DEF_PFN_W     = 21;
   localparam int unsigned DEF_WORD_W    = 32;
   localparam int unsigned DEF_VALID_POS = 31;
endpackage

// File: rtl/dmamap_table.sv
module dmamap_table #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rda_idx,
   output logic [WORD_W-1:0] rda_word,
   input  logic [IDX_W-1:0]  rdb_idx,
   output logic [WORD_W-1:0] rdb_word
);
   localparam int unsigned SLOTS = 1 << IDX_W;

   logic [WORD_W-1:0] slot_q [SLOTS];

   // Reads are combinational from the current contents, so a write in the
   // same cycle is seen only from the next cycle on.
   assign rda_word = slot_q[rda_idx];
   assign rdb_word = slot_q[rdb_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
      end else if (wr_en) begin
         slot_q[wr_idx] <= wr_word;
      end
   end
endmodule

// File: rtl/dmamap_host_port.sv
module dmamap_host_port #(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned PFN_W       = 21,
   parameter int unsigned VALID_POS   = 31,
   parameter bit          HOST_RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] wr_word,
   input  logic [WORD_W-1:0] tbl_word,
   output logic [WORD_W-1:0] rdata
);
   localparam logic [WORD_W-1:0] KEEP_MASK =
      (WORD_W'(1) << VALID_POS) | ((WORD_W'(1) << PFN_W) - WORD_W'(1));

   // Bits outside the flag and frame fields are never stored; they become
   // constant-zero flops in the table and are pruned.
   assign wr_word = wdata & KEEP_MASK;

   generate
      if (HOST_RD_REG) begin : g_rd_reg
         logic [WORD_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= tbl_word;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? tbl_word : '0;
      end
   endgenerate
endmodule

// File: rtl/dmamap_lookup.sv
module dmamap_lookup
   import dmamap_pkg::*;
#(
   parameter int unsigned VA_W      = 17,
   parameter int unsigned OFS_W     = 9,
   parameter int unsigned PFN_W     = 21,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned VALID_POS = 31,
   localparam int unsigned IDX_W    = VA_W - OFS_W,
   localparam int unsigned PA_W     = PFN_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              xl_req,
   input  logic [VA_W-1:0]   xl_va,
   output logic [IDX_W-1:0]  tbl_idx,
   input  logic [WORD_W-1:0] tbl_word,
   output logic              xl_done,
   output logic              xl_ok,
   output logic [PA_W-1:0]   xl_pa,
   output logic              inv_map_err,
   output logic [WORD_W-1:0] smr
);
   xl_stat_e          stat_q;
   logic [PA_W-1:0]   pa_q;
   logic [WORD_W-1:0] smr_q;
   logic              accept;
   logic              hit;

   assign tbl_idx = xl_va[VA_W-1:OFS_W];
   assign accept  = xl_req && !init;
   assign hit     = tbl_word[VALID_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= XL_IDLE;
         pa_q   <= '0;
         smr_q  <= '0;
      end else if (init) begin
         stat_q <= XL_IDLE;
         smr_q  <= '0;
      end else if (accept) begin
         smr_q  <= tbl_word;
         stat_q <= hit ? XL_HIT : XL_MISS;
         pa_q   <= hit ? {tbl_word[PFN_W-1:0], xl_va[OFS_W-1:0]} : '0;
      end else begin
         stat_q <= XL_IDLE;
      end
   end

   assign xl_done     = (stat_q != XL_IDLE);
   assign xl_ok       = (stat_q == XL_HIT);
   assign inv_map_err = (stat_q == XL_MISS);
   assign xl_pa       = pa_q;
   assign smr         = smr_q;
endmodule

// File: rtl/dmamap_xlate.sv
module dmamap_xlate
   import dmamap_pkg::*;
#(
   parameter int unsigned VA_W        = DEF_VA_W,
   parameter int unsigned OFS_W       = DEF_OFS_W,
   parameter int unsigned PFN_W       = DEF_PFN_W,
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned VALID_POS   = DEF_VALID_POS,
   parameter bit          HOST_RD_REG = 1'b1,
   localparam int unsigned IDX_W      = VA_W - OFS_W,
   localparam int unsigned PA_W       = PFN_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              xl_req,
   input  logic [VA_W-1:0]   xl_va,
   output logic              xl_done,
   output logic              xl_ok,
   output logic [PA_W-1:0]   xl_pa,
   output logic              inv_map_err,
   output logic [WORD_W-1:0] smr
);
   generate
      if (VA_W <= OFS_W) begin : g_bad_va
         $error("dmamap_xlate: VA_W must exceed OFS_W");
      end
      if (IDX_W > 12) begin : g_bad_idx
         $error("dmamap_xlate: map index too wide for a flop table");
      end
      if (VALID_POS >= WORD_W || VALID_POS < PFN_W) begin : g_bad_valid
         $error("dmamap_xlate: valid flag must sit above the frame field");
      end
   endgenerate

   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] host_tbl_word;
   logic [IDX_W-1:0]  lk_idx;
   logic [WORD_W-1:0] lk_word;

   dmamap_host_port #(
      .WORD_W(WORD_W), .PFN_W(PFN_W), .VALID_POS(VALID_POS),
      .HOST_RD_REG(HOST_RD_REG)
   ) u_host (
      .clk(clk), .rst_n(rst_n), .rd_en(host_rd), .wdata(host_wdata),
      .wr_word(wr_word), .tbl_word(host_tbl_word), .rdata(host_rdata)
   );

   dmamap_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr), .wr_idx(host_idx), .wr_word(wr_word),
      .rda_idx(host_idx), .rda_word(host_tbl_word),
      .rdb_idx(lk_idx), .rdb_word(lk_word)
   );

   dmamap_lookup #(
      .VA_W(VA_W), .OFS_W(OFS_W), .PFN_W(PFN_W),
      .WORD_W(WORD_W), .VALID_POS(VALID_POS)
   ) u_lookup (
      .clk(clk), .rst_n(rst_n), .init(init),
      .xl_req(xl_req), .xl_va(xl_va),
      .tbl_idx(lk_idx), .tbl_word(lk_word),
      .xl_done(xl_done), .xl_ok(xl_ok), .xl_pa(xl_pa),
      .inv_map_err(inv_map_err), .smr(smr)
   );
endmodule

// File: rtl/dmamap_xlate_chk.sv
module dmamap_xlate_chk #(
   parameter int unsigned VA_W      = 17,
   parameter int unsigned OFS_W     = 9,
   parameter int unsigned PA_W      = 30,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned VALID_POS = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init,
   input logic              xl_req,
   input logic [VA_W-1:0]   xl_va,
   input logic              xl_done,
   input logic              xl_ok,
   input logic [PA_W-1:0]   xl_pa,
   input logic              inv_map_err,
   input logic [WORD_W-1:0] smr
);
   // R3
   req_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && !init) |=> xl_done);

   // R3
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && !init) |=> (!xl_ok || xl_pa[OFS_W-1:0] == $past(xl_va[OFS_W-1:0])));

   // R5
   miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_map_err |-> (xl_done && !xl_ok && xl_pa == '0));

   // R6
   smr_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_done |-> (xl_ok == smr[VALID_POS]));

   // R7
   init_clears_smr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (smr == '0 && !xl_done));

   // R9
   idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_req |=> (!xl_done && !inv_map_err));
endmodule

bind dmamap_xlate dmamap_xlate_chk #(
   .VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .WORD_W(WORD_W), .VALID_POS(VALID_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .init(init), .xl_req(xl_req), .xl_va(xl_va),
   .xl_done(xl_done), .xl_ok(xl_ok), .xl_pa(xl_pa),
   .inv_map_err(inv_map_err), .smr(smr)
);

// File: tb/dmamap_xlate_tb.sv
module dmamap_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_idx = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        xl_req = 1'b0;
   logic [16:0] xl_va = '0;
   logic        xl_done;
   logic        xl_ok;
   logic [29:0] xl_pa;
   logic        inv_map_err;
   logic [31:0] smr;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dmamap_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .init(init),
      .host_wr(host_wr), .host_rd(host_rd), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .xl_req(xl_req), .xl_va(xl_va), .xl_done(xl_done), .xl_ok(xl_ok),
      .xl_pa(xl_pa), .inv_map_err(inv_map_err), .smr(smr)
   );

   task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic host_write(logic [7:0] idx, logic [31:0] data);
      @(negedge clk);
      host_wr = 1'b1; host_idx = idx; host_wdata = data;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [7:0] idx, output logic [31:0] data);
      @(negedge clk);
      host_rd = 1'b1; host_idx = idx;
      @(posedge clk); #1;
      data = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic lookup(logic [16:0] va);
      @(negedge clk);
      xl_req = 1'b1; xl_va = va;
      @(posedge clk); #1;
   endtask

   task automatic idle_after(string req);
      @(negedge clk);
      xl_req = 1'b0; init = 1'b0; host_wr = 1'b0;
      @(posedge clk); #1;
      chk(req, "done after idle", 64'(xl_done), 64'd0);
      chk(req, "err after idle", 64'(inv_map_err), 64'd0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1", "smr at reset", 64'(smr), 64'd0);
      chk("R1", "done at reset", 64'(xl_done), 64'd0);
      chk("R1", "err at reset", 64'(inv_map_err), 64'd0);
      chk("R1", "pa at reset", 64'(xl_pa), 64'd0);
      host_read(8'd0, d);   chk("R1", "slot 0", 64'(d), 64'd0);
      host_read(8'd255, d); chk("R1", "slot 255", 64'(d), 64'd0);
   endtask

   task automatic t_write_mask();
      logic [31:0] d;
      host_write(8'd5, 32'hFFFF_FFFF);
      host_read(8'd5, d); chk("R2", "all-ones masked", 64'(d), 64'h801F_FFFF);
      host_write(8'd6, 32'h7FE0_0000);
      host_read(8'd6, d); chk("R2", "only dropped bits", 64'(d), 64'd0);
   endtask

   task automatic t_hit();
      host_write(8'd3, 32'h8000_1234);
      lookup({8'd3, 9'h1A5});
      chk("R3", "done", 64'(xl_done), 64'd1);
      chk("R3", "pa", 64'(xl_pa), 64'({21'h1234, 9'h1A5}));
      chk("R4", "ok", 64'(xl_ok), 64'd1);
      chk("R4", "no err", 64'(inv_map_err), 64'd0);
      chk("R6", "smr on hit", 64'(smr), 64'h8000_1234);
      idle_after("R9");
   endtask

   task automatic t_miss();
      host_write(8'd7, 32'h0000_0ABC);
      lookup({8'd7, 9'h055});
      chk("R5", "ok low", 64'(xl_ok), 64'd0);
      chk("R5", "err", 64'(inv_map_err), 64'd1);
      chk("R5", "pa zero", 64'(xl_pa), 64'd0);
      chk("R6", "smr on miss", 64'(smr), 64'h0000_0ABC);
      idle_after("R9");
   endtask

   task automatic t_init();
      logic [31:0] d;
      lookup({8'd3, 9'h000});
      chk("R6", "smr before init", 64'(smr), 64'h8000_1234);
      @(negedge clk); xl_req = 1'b0; init = 1'b1;
      @(posedge clk); #1;
      chk("R7", "smr cleared", 64'(smr), 64'd0);
      @(negedge clk); init = 1'b0;
      host_read(8'd3, d); chk("R7", "table kept", 64'(d), 64'h8000_1234);
      @(negedge clk); init = 1'b1; xl_req = 1'b1; xl_va = {8'd3, 9'h001};
      @(posedge clk); #1;
      chk("R7", "lookup dropped", 64'(xl_done), 64'd0);
      chk("R7", "smr stays zero", 64'(smr), 64'd0);
      idle_after("R9");
   endtask

   task automatic t_collision();
      logic [31:0] d;
      host_write(8'd9, 32'h8000_0011);
      @(negedge clk);
      host_wr = 1'b1; host_idx = 8'd9; host_wdata = 32'h8000_0022;
      xl_req = 1'b1; xl_va = {8'd9, 9'h010};
      @(posedge clk); #1;
      chk("R8", "old pa", 64'(xl_pa), 64'({21'h11, 9'h010}));
      chk("R8", "old smr", 64'(smr), 64'h8000_0011);
      @(negedge clk); host_wr = 1'b0; xl_req = 1'b0;
      lookup({8'd9, 9'h010});
      chk("R8", "new pa", 64'(xl_pa), 64'({21'h22, 9'h010}));
      @(negedge clk); xl_req = 1'b0;
      host_read(8'd9, d); chk("R8", "write landed", 64'(d), 64'h8000_0022);
   endtask

   task automatic t_bounds();
      host_write(8'd255, 32'h801F_FFFF);
      lookup({8'd255, 9'h1FF});
      chk("R3", "top slot max pa", 64'(xl_pa), 64'h3FFF_FFFF);
      host_write(8'd0, 32'h8000_0001);
      lookup({8'd0, 9'h000});
      chk("R3", "slot 0 pa", 64'(xl_pa), 64'h0000_0200);
      chk("R4", "slot 0 ok", 64'(xl_ok), 64'd1);
      idle_after("R9");
   endtask

   task automatic t_powerup();
      logic [31:0] d;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      host_read(8'd3, d); chk("R1", "slot 3 wiped", 64'(d), 64'd0);
      chk("R1", "smr wiped", 64'(smr), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_write_mask();
      t_hit();
      t_miss();
      t_init();
      t_collision();
      t_bounds();
      t_powerup();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule